// File: doc/BRIEF.md
# PIO Timing Register Encoder

This block turns drive timing figures, already expressed as bus clock counts, into the two byte values that a dual-channel disk controller keeps for programmed-I/O transfers: an address-setup byte and a packed active/recovery byte. The caller supplies the active, recovery and setup counts for one drive, selects the channel and drive, and hands in the present contents of the address-setup register. The block returns the new address-setup byte, built by read-modify-write so that unrelated low bits survive. It also returns the packed timing byte and the register addresses the two bytes belong to.

Counts that do not fit the hardware fields are adjusted first. Recovery time beyond the field limit is moved into active time, and active time is then clamped. The field encodings are not linear: a count of 16 is written as 0, a short recovery becomes the longest code, and setup goes through a small lookup with a saturating code. On the secondary channel the two drives share one setup field, so the block can take the companion drive's setup count and keep the slower of the two.

One request is accepted per cycle. The results appear on registered outputs one cycle later, together with a single-cycle valid pulse.

Top module: `pio_timing_encoder`

## Requirements
- R1: After reset `out_valid` is 0 and `setup_byte`, `timing_byte`, `setup_addr` and `timing_addr` are all 0.
- R2: A request with `in_valid` high at a clock edge sets `out_valid` high for exactly the following cycle, carrying that request's results. Without a request, `out_valid` is low.
- R3: When the recovery count exceeds 16, the excess over 16 is added to the active count and recovery becomes 16.
- R4: After the step in R3, an active count above 16 is clamped to 16. The active code is the count modulo 16, so 16 is written as 0.
- R5: A recovery count above 1 is encoded as the count minus one. A recovery count of 0 or 1 is encoded as 15.
- R6: The packed timing byte holds the active code in bits 7:4 and the recovery code in bits 3:0.
- R7: The setup code is 2'b01 for counts 0 to 2, 2'b10 for 3, 2'b00 for 4 and 2'b11 for any count above 4.
- R8: `setup_byte` bits 7:6 hold the setup code and bits 5:0 equal bits 5:0 of `prev_setup_reg`.
- R9: On the secondary channel (`chan_sel`=1) with `pair_present`=1, the setup count used is the larger of `setup_cnt` and `pair_setup_cnt`. On the primary channel, or with `pair_present`=0, `pair_setup_cnt` has no effect.
- R10: On the primary channel `setup_addr` is 0x53 plus twice `drive_sel`, and `timing_addr` is `setup_addr`+1. On the secondary channel `setup_addr` is 0x57 and `timing_addr` is 0x58, whatever the drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| chan_sel | input | 1 | 0 selects the primary channel, 1 the secondary |
| drive_sel | input | 1 | Drive number on the channel |
| act_cnt | input | 5 | Active time in bus clocks |
| rec_cnt | input | 5 | Recovery time in bus clocks |
| setup_cnt | input | 5 | Address-setup time in bus clocks |
| pair_present | input | 1 | Companion drive on the channel is present |
| pair_setup_cnt | input | 5 | Companion drive's setup time in bus clocks |
| prev_setup_reg | input | 8 | Current value of the address-setup register |
| out_valid | output | 1 | Result valid pulse |
| setup_byte | output | 8 | New address-setup register value |
| timing_byte | output | 8 | Packed active/recovery value |
| setup_addr | output | 8 | Address of the address-setup register |
| timing_addr | output | 8 | Address of the active/recovery register |

## Verification
The assertions take for granted that `in_valid` is held low during reset and that every input is at a known value whenever `in_valid` is high, since results are captured only on a strobe. They also rely on the outputs being checked only while `out_valid` is high. The bench drives all inputs on the falling edge, raises `in_valid` for one cycle per request and drops it afterwards. It sweeps every count across the full 5-bit range, including the fold and clamp boundaries at 1, 16 and 17.

// File: rtl/pio_timing_encoder.sv
module pio_timing_encoder #(
  parameter int CNT_W = 5,
  parameter int ADDR_W = 8,
  parameter int CLK_LIMIT = 16,
  parameter logic [7:0] PRI_BASE = 8'h53,
  parameter logic [7:0] SEC_SETUP_ADDR = 8'h57,
  parameter logic [7:0] SEC_TIMING_ADDR = 8'h58
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             chan_sel,
  input  logic             drive_sel,
  input  logic [CNT_W-1:0] act_cnt,
  input  logic [CNT_W-1:0] rec_cnt,
  input  logic [CNT_W-1:0] setup_cnt,
  input  logic             pair_present,
  input  logic [CNT_W-1:0] pair_setup_cnt,
  input  logic [7:0]       prev_setup_reg,
  output logic             out_valid,
  output logic [7:0]       setup_byte,
  output logic [7:0]       timing_byte,
  output logic [ADDR_W-1:0] setup_addr,
  output logic [ADDR_W-1:0] timing_addr
);

  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] LIM = SUM_W'(CLK_LIMIT);
  localparam logic [SUM_W-1:0] ONE = SUM_W'(1);

  logic [CNT_W-1:0] setup_eff;
  logic [SUM_W-1:0] act_ext, rec_ext, act_fold, rec_fold, act_cl;
  logic [3:0]       act_code, rec_code;
  logic [1:0]       setup_code;
  logic [ADDR_W-1:0] s_addr, t_addr;

  assign setup_eff = (chan_sel && pair_present && (pair_setup_cnt > setup_cnt))
                     ? pair_setup_cnt : setup_cnt;

  assign act_ext = SUM_W'(act_cnt);
  assign rec_ext = SUM_W'(rec_cnt);

  always_comb begin
    if (rec_ext > LIM) begin
      act_fold = act_ext + rec_ext - LIM;
      rec_fold = LIM;
    end else begin
      act_fold = act_ext;
      rec_fold = rec_ext;
    end
  end

  assign act_cl   = (act_fold > LIM) ? LIM : act_fold;
  assign act_code = act_cl[3:0];
  assign rec_code = (rec_fold > ONE) ? 4'(rec_fold - ONE) : 4'hF;

  always_comb begin
    if (setup_eff <= CNT_W'(2))       setup_code = 2'b01;
    else if (setup_eff == CNT_W'(3))  setup_code = 2'b10;
    else if (setup_eff == CNT_W'(4))  setup_code = 2'b00;
    else                              setup_code = 2'b11;
  end

  assign s_addr = chan_sel ? ADDR_W'(SEC_SETUP_ADDR)
                           : ADDR_W'(PRI_BASE) + ADDR_W'({drive_sel, 1'b0});
  assign t_addr = chan_sel ? ADDR_W'(SEC_TIMING_ADDR) : s_addr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      setup_byte  <= '0;
      timing_byte <= '0;
      setup_addr  <= '0;
      timing_addr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        setup_byte  <= {setup_code, prev_setup_reg[5:0]};
        timing_byte <= {act_code, rec_code};
        setup_addr  <= s_addr;
        timing_addr <= t_addr;
      end
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  low_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> setup_byte[5:0] == $past(prev_setup_reg[5:0]));

  // R5
  rec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> timing_byte[3:0] != 4'h0);

  // R3
  rec_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rec_cnt > CNT_W'(CLK_LIMIT)) |=> timing_byte[3:0] == 4'hF);

  // R10
  addr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> timing_addr == setup_addr + ADDR_W'(1));

endmodule

// File: tb/sim_pio_timing_encoder.sv
module sim_pio_timing_encoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic chan_sel = 1'b0, drive_sel = 1'b0, pair_present = 1'b0;
  logic [4:0] act_cnt = '0, rec_cnt = '0, setup_cnt = '0, pair_setup_cnt = '0;
  logic [7:0] prev_setup_reg = '0;
  logic out_valid;
  logic [7:0] setup_byte, timing_byte, setup_addr, timing_addr;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_timing_encoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .chan_sel(chan_sel),
    .drive_sel(drive_sel), .act_cnt(act_cnt), .rec_cnt(rec_cnt),
    .setup_cnt(setup_cnt), .pair_present(pair_present),
    .pair_setup_cnt(pair_setup_cnt), .prev_setup_reg(prev_setup_reg),
    .out_valid(out_valid), .setup_byte(setup_byte), .timing_byte(timing_byte),
    .setup_addr(setup_addr), .timing_addr(timing_addr));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_timing(int a, int r);
    int aa = a, rr = r, ac, rc;
    if (rr > 16) begin aa = aa + rr - 16; rr = 16; end
    if (aa > 16) aa = 16;
    ac = aa % 16;
    rc = (rr > 1) ? rr - 1 : 15;
    return 8'((ac << 4) | rc);
  endfunction

  function automatic logic [1:0] exp_code(int s);
    if (s <= 2) return 2'b01;
    if (s == 3) return 2'b10;
    if (s == 4) return 2'b00;
    return 2'b11;
  endfunction

  task automatic issue(logic ch, logic dr, int a, int r, int s, logic pp, int ps, logic [7:0] prev);
    @(negedge clk);
    chan_sel = ch; drive_sel = dr; act_cnt = 5'(a); rec_cnt = 5'(r);
    setup_cnt = 5'(s); pair_present = pp; pair_setup_cnt = 5'(ps);
    prev_setup_reg = prev; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 out_valid", {7'b0, out_valid}, 8'h00);
    check("R1 setup_byte", setup_byte, 8'h00);
    check("R1 timing_byte", timing_byte, 8'h00);
    check("R1 setup_addr", setup_addr, 8'h00);
    check("R1 timing_addr", timing_addr, 8'h00);
  endtask

  task automatic t_pulse;
    issue(1'b0, 1'b0, 5, 5, 2, 1'b0, 0, 8'h00);
    check("R2 valid high", {7'b0, out_valid}, 8'h01);
    @(negedge clk);
    check("R2 valid low after", {7'b0, out_valid}, 8'h00);
  endtask

  task automatic t_timing_sweep;
    for (int a = 0; a < 32; a++)
      for (int r = 0; r < 32; r++) begin
        issue(1'b0, 1'b0, a, r, 0, 1'b0, 0, 8'h00);
        check("R3 R4 R5 R6 timing sweep", timing_byte, exp_timing(a, r));
      end
  endtask

  task automatic t_corners;
    issue(1'b0, 1'b0, 3, 20, 0, 1'b0, 0, 8'h00);
    check("R3 fold 3/20", timing_byte, 8'h7F);
    issue(1'b0, 1'b0, 16, 10, 0, 1'b0, 0, 8'h00);
    check("R4 active 16 as 0", timing_byte, 8'h09);
    issue(1'b0, 1'b0, 30, 31, 0, 1'b0, 0, 8'h00);
    check("R4 clamp after fold", timing_byte, 8'h0F);
    issue(1'b0, 1'b0, 2, 1, 0, 1'b0, 0, 8'h00);
    check("R5 recovery 1", timing_byte, 8'h2F);
    issue(1'b0, 1'b0, 2, 0, 0, 1'b0, 0, 8'h00);
    check("R5 recovery 0", timing_byte, 8'h2F);
    issue(1'b0, 1'b0, 5, 2, 0, 1'b0, 0, 8'h00);
    check("R5 R6 recovery 2", timing_byte, 8'h51);
  endtask

  task automatic t_setup;
    for (int s = 0; s < 32; s++) begin
      issue(1'b0, 1'b1, 4, 4, s, 1'b0, 0, 8'hA5);
      check("R7 R8 setup table", setup_byte, {exp_code(s), 6'h25});
    end
    issue(1'b0, 1'b0, 4, 4, 3, 1'b0, 0, 8'hFF);
    check("R8 low bits kept", setup_byte, 8'hBF);
  endtask

  task automatic t_merge;
    issue(1'b1, 1'b0, 4, 4, 1, 1'b1, 5, 8'h0C);
    check("R9 secondary pair larger", setup_byte, 8'hCC);
    issue(1'b1, 1'b1, 4, 4, 4, 1'b1, 3, 8'h0C);
    check("R9 secondary own larger", setup_byte, 8'h0C);
    issue(1'b1, 1'b0, 4, 4, 1, 1'b0, 5, 8'h0C);
    check("R9 no pair ignored", setup_byte, 8'h4C);
    issue(1'b0, 1'b0, 4, 4, 3, 1'b1, 9, 8'h00);
    check("R9 primary ignores pair", setup_byte, 8'h80);
  endtask

  task automatic t_addr;
    issue(1'b0, 1'b0, 4, 4, 0, 1'b0, 0, 8'h00);
    check("R10 pri d0 setup", setup_addr, 8'h53);
    check("R10 pri d0 timing", timing_addr, 8'h54);
    issue(1'b0, 1'b1, 4, 4, 0, 1'b0, 0, 8'h00);
    check("R10 pri d1 setup", setup_addr, 8'h55);
    check("R10 pri d1 timing", timing_addr, 8'h56);
    for (int d = 0; d < 2; d++) begin
      issue(1'b1, 1'(d), 4, 4, 0, 1'b0, 0, 8'h00);
      check("R10 sec setup", setup_addr, 8'h57);
      check("R10 sec timing", timing_addr, 8'h58);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_pulse();
    t_corners();
    t_timing_sweep();
    t_setup();
    t_merge();
    t_addr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule